// File: doc/BRIEF.md
# Processor Hardware Return Stack

This block is the on-chip return stack of a small processor core. It keeps the context that subroutine calls, long interrupt service routines and nested hardware loops need in order to resume. Each level holds two words: a high word with the return address and a low word with the saved status. The two words of the top level come out on separate ports, so the core can read either one without the other. The core's control unit sends push and pop requests. A 4-bit pointer gives the current level, and the core can read and load it to save and restore the pointer when it switches tasks.

The pointer runs from 0 (empty) up to 15, which gives fifteen usable levels. If a push at level 15 or a pop at level 0 wraps the pointer, the block sets a sticky overflow or underflow indicator for the status register. It also sends a one-cycle stack-error request to the interrupt controller. This trap is for diagnosis only: the block saves no extra context, and a push that overflows simply writes its words into slot 0. An entry into a fast interrupt routine uses no stack level, so the block drops a push request that arrives together with the fast-entry strobe.

Top module: `retstack`

## Requirements
- R1: After reset the pointer is 0, both indicators and the error request are 0, and every slot reads as zero.
- R2: A push without a pop, fast strobe or pointer load increments the pointer. It writes the high and low words into the slot at the new level, and both words appear on the top-word outputs in the next cycle. Levels 1 to 15 hold fifteen distinct entries.
- R3: The top words can be read before a pop. A pop decrements the pointer, and the top-word outputs then show the entry one level down.
- R4: A push and a pop in the same cycle overwrite the current top slot with the pushed words. The pointer does not change, and no indicator or error is raised.
- R5: When the fast-interrupt strobe is high, a push request is dropped, so the pointer and the stored words stay as they were. A pop in the same cycle still goes ahead.
- R6: A push at level 15 wraps the pointer to 0 and writes the pushed words into slot 0. Overflow (status bit 0) is set and the error request pulses. Both show in the cycle after the push.
- R7: A pop at level 0 wraps the pointer to 15. Underflow (status bit 1) is set and the error request pulses. Both show in the cycle after the pop.
- R8: Both indicators are sticky. They change only through reset or a status write, which loads bit 0 into overflow and bit 1 into underflow. If a wrap happens in the same cycle as a status write, the wrap sets its indicator.
- R9: A pointer load sets the pointer to the written value in the next cycle. In that cycle the block ignores any push or pop and leaves the stored words unchanged.
- R10: The error request is 1 for exactly one cycle after each wrap and is 0 at all other times. Reaching level 15 or level 0 without a wrap does not raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push_req | input | 1 | Push request from the control unit |
| pop_req | input | 1 | Pop request from the control unit |
| fast_irq | input | 1 | Fast-interrupt entry strobe; drops any push in the same cycle |
| push_hi | input | AW | Return address to push |
| push_lo | input | SW | Status word to push |
| sp_wr | input | 1 | Pointer load strobe |
| sp_wdata | input | PW | Pointer value to load |
| flag_wr | input | 1 | Status write strobe for the indicators |
| flag_wdata | input | 2 | Bit 0 = overflow, bit 1 = underflow |
| sp | output | PW | Current stack pointer |
| top_hi | output | AW | High word (return address) of the current level |
| top_lo | output | SW | Low word (status) of the current level |
| ovf_flag | output | 1 | Sticky overflow indicator |
| unf_flag | output | 1 | Sticky underflow indicator |
| stk_err | output | 1 | One-cycle stack-error request |

## Verification
Three pairs of functions can fall in the same cycle: a wrap and a status write, a push and a pop, and a push and a pointer load. In each case one function must take priority, and getting that priority wrong leaves no other symptom. The vector table drives each pair in a single cycle. One case is a pop at level 0 together with a write of zeros to the indicators. The result is judged in the next cycle from the pointer, the top words, both indicators and the error pulse. A directed fill-and-drain pass writes fifteen distinct entries and reads them back in reverse order, with no indicator raised.

// File: rtl/rstk_pkg.sv
// Shared types for the return stack.
// Assumes: the pointer width is fixed in each instance and shared by all submodules.
package rstk_pkg;

    // Operation the stack carries out in a cycle, after priority and gating.
    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_PUSH = 2'd1,
        OP_POP  = 2'd2,
        OP_SWAP = 2'd3
    } rstk_op_e;

    // Turns the raw requests into one operation.
    // A pointer load blocks both push and pop; the fast strobe blocks push only.
    function automatic rstk_op_e rstk_decode(input logic push, input logic pop,
                                             input logic fast, input logic load);
        logic p_ok;
        logic q_ok;
        p_ok = push & ~fast & ~load;
        q_ok = pop & ~load;
        case ({p_ok, q_ok})
            2'b10:   return OP_PUSH;
            2'b01:   return OP_POP;
            2'b11:   return OP_SWAP;
            default: return OP_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/rstk_ptr.sv
// Stack pointer unit.
// Keeps the level register, works out which slot to write, and reports wraps.
// Assumes: the pointer wraps modulo 2**PW, and level 0 means empty.
module rstk_ptr
    import rstk_pkg::*;
#(
    parameter int PW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  rstk_op_e      op,
    input  logic          load,
    input  logic [PW-1:0] load_val,
    output logic [PW-1:0] sp,
    output logic          wr_en,
    output logic [PW-1:0] wr_idx,
    output logic          ovf_evt,
    output logic          unf_evt
);
    localparam logic [PW-1:0] TOP_LVL = {PW{1'b1}};
    localparam logic [PW-1:0] ONE     = {{(PW-1){1'b0}}, 1'b1};

    logic [PW-1:0] sp_inc;
    logic [PW-1:0] sp_dec;
    logic [PW-1:0] sp_nxt;

    assign sp_inc = sp + ONE;
    assign sp_dec = sp - ONE;

    // Chooses the write slot: the next level for a push, the current level for a swap.
    always_comb begin
        wr_en  = (op == OP_PUSH) || (op == OP_SWAP);
        wr_idx = (op == OP_PUSH) ? sp_inc : sp;
    end

    // Flags a wrap past either end of the pointer range.
    always_comb begin
        ovf_evt = (op == OP_PUSH) && (sp == TOP_LVL);
        unf_evt = (op == OP_POP)  && (sp == '0);
    end

    // Works out the next pointer value; a load takes priority.
    always_comb begin
        if (load) begin
            sp_nxt = load_val;
        end else begin
            case (op)
                OP_PUSH: sp_nxt = sp_inc;
                OP_POP:  sp_nxt = sp_dec;
                default: sp_nxt = sp;
            endcase
        end
    end

    // Pointer register.
    always_ff @(posedge clk) begin
        if (!rst_n) sp <= '0;
        else        sp <= sp_nxt;
    end

endmodule

// File: rtl/rstk_bank.sv
// One word lane of the stack storage: 2**PW slots of W bits.
// There is one write port and one combinational read port.
// Assumes: write index and read index are both in range (full-width pointer).
module rstk_bank #(
    parameter int W  = 16,
    parameter int PW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [PW-1:0] wr_idx,
    input  logic [W-1:0]  wr_data,
    input  logic [PW-1:0] rd_idx,
    output logic [W-1:0]  rd_data
);
    localparam int N = 1 << PW;

    logic [W-1:0] slot [N];

    for (genvar g = 0; g < N; g++) begin : g_slot
        // Slot register: cleared on reset, loaded when selected.
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot[g] <= '0;
            else if (wr_en && (wr_idx == PW'(g)))
                slot[g] <= wr_data;
        end
    end

    // Reads the slot at the current level.
    assign rd_data = slot[rd_idx];

endmodule

// File: rtl/rstk_flags.sv
// Sticky overflow/underflow indicators and the one-cycle stack-error request.
// Assumes: a wrap event takes priority over a status write in the same cycle.
module rstk_flags (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ovf_evt,
    input  logic       unf_evt,
    input  logic       flag_wr,
    input  logic [1:0] flag_wdata,
    output logic       ovf_flag,
    output logic       unf_flag,
    output logic       stk_err
);
    // Overflow indicator: a wrap sets it, a status write loads it, otherwise it holds.
    always_ff @(posedge clk) begin
        if (!rst_n)       ovf_flag <= 1'b0;
        else if (ovf_evt) ovf_flag <= 1'b1;
        else if (flag_wr) ovf_flag <= flag_wdata[0];
    end

    // Underflow indicator: same rules, bit 1 of the status write.
    always_ff @(posedge clk) begin
        if (!rst_n)       unf_flag <= 1'b0;
        else if (unf_evt) unf_flag <= 1'b1;
        else if (flag_wr) unf_flag <= flag_wdata[1];
    end

    // Error request: high for one cycle, in the same cycle as the indicator update.
    always_ff @(posedge clk) begin
        if (!rst_n) stk_err <= 1'b0;
        else        stk_err <= ovf_evt | unf_evt;
    end

endmodule

// File: rtl/retstack.sv
// Hardware return stack: two-word levels (return address, status) with a
// wrapping pointer, sticky wrap indicators and a diagnostic error request.
// Assumes: requests are single-cycle strobes from the control unit, and the
// block saves no context on an error trap.
module retstack
    import rstk_pkg::*;
#(
    parameter int AW = 16,
    parameter int SW = 16,
    parameter int PW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_req,
    input  logic          pop_req,
    input  logic          fast_irq,
    input  logic [AW-1:0] push_hi,
    input  logic [SW-1:0] push_lo,
    input  logic          sp_wr,
    input  logic [PW-1:0] sp_wdata,
    input  logic          flag_wr,
    input  logic [1:0]    flag_wdata,
    output logic [PW-1:0] sp,
    output logic [AW-1:0] top_hi,
    output logic [SW-1:0] top_lo,
    output logic          ovf_flag,
    output logic          unf_flag,
    output logic          stk_err
);
    rstk_op_e      op;
    logic          wr_en;
    logic [PW-1:0] wr_idx;
    logic          ovf_evt;
    logic          unf_evt;

    // Resolves the operation for this cycle.
    assign op = rstk_decode(push_req, pop_req, fast_irq, sp_wr);

    rstk_ptr #(.PW(PW)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (op),
        .load     (sp_wr),
        .load_val (sp_wdata),
        .sp       (sp),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .ovf_evt  (ovf_evt),
        .unf_evt  (unf_evt)
    );

    rstk_bank #(.W(AW), .PW(PW)) u_hi (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (push_hi),
        .rd_idx  (sp),
        .rd_data (top_hi)
    );

    rstk_bank #(.W(SW), .PW(PW)) u_lo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (push_lo),
        .rd_idx  (sp),
        .rd_data (top_lo)
    );

    rstk_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .ovf_evt    (ovf_evt),
        .unf_evt    (unf_evt),
        .flag_wr    (flag_wr),
        .flag_wdata (flag_wdata),
        .ovf_flag   (ovf_flag),
        .unf_flag   (unf_flag),
        .stk_err    (stk_err)
    );

endmodule

// File: rtl/rstk_checker.sv
// Protocol checks for the return stack, attached by bind.
// Assumes: checks are relative to the top-level ports only.
module rstk_checker #(
    parameter int AW = 16,
    parameter int SW = 16,
    parameter int PW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          push_req,
    input logic          pop_req,
    input logic          fast_irq,
    input logic [AW-1:0] push_hi,
    input logic [SW-1:0] push_lo,
    input logic          sp_wr,
    input logic [PW-1:0] sp_wdata,
    input logic          flag_wr,
    input logic [1:0]    flag_wdata,
    input logic [PW-1:0] sp,
    input logic [AW-1:0] top_hi,
    input logic [SW-1:0] top_lo,
    input logic          ovf_flag,
    input logic          unf_flag,
    input logic          stk_err
);
    localparam logic [PW-1:0] TOP_LVL = {PW{1'b1}};

    logic solo_push;
    logic solo_pop;
    assign solo_push = push_req && !pop_req && !fast_irq && !sp_wr;
    assign solo_pop  = pop_req && !push_req && !sp_wr;

    // R2: a plain push moves the pointer up by one and shows the pushed words
    a_r2_push_up: assert property (@(posedge clk) disable iff (!rst_n)
        solo_push |=> (sp == PW'($past(sp) + 1'b1)) && (top_hi == $past(push_hi))
                      && (top_lo == $past(push_lo)));

    // R3: a plain pop moves the pointer down by one
    a_r3_pop_down: assert property (@(posedge clk) disable iff (!rst_n)
        solo_pop |=> (sp == PW'($past(sp) - 1'b1)));

    // R4: push and pop together keep the pointer and replace the top words
    a_r4_swap: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && pop_req && !fast_irq && !sp_wr) |=>
            $stable(sp) && (top_hi == $past(push_hi)) && !stk_err);

    // R5: a fast-interrupt entry never pushes
    a_r5_fast_no_push: assert property (@(posedge clk) disable iff (!rst_n)
        (fast_irq && !pop_req && !sp_wr) |=> $stable(sp) && $stable(top_hi) && $stable(top_lo));

    // R6: a push at the top level wraps and raises overflow with the error request
    a_r6_ovf_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (solo_push && sp == TOP_LVL) |=> (sp == '0) && ovf_flag && stk_err);

    // R7: a pop at level 0 wraps and raises underflow with the error request
    a_r7_unf_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (solo_pop && sp == '0) |=> (sp == TOP_LVL) && unf_flag && stk_err);

    // R8: without a status write the indicators never fall
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_wr |=> !$fell(ovf_flag) && !$fell(unf_flag));

    // R9: a pointer load takes effect in the next cycle
    a_r9_load: assert property (@(posedge clk) disable iff (!rst_n)
        sp_wr |=> (sp == $past(sp_wdata)));

    // R10: the error request comes only with a raised indicator
    a_r10_err_flag: assert property (@(posedge clk) disable iff (!rst_n)
        stk_err |-> (ovf_flag || unf_flag));

endmodule

bind retstack rstk_checker #(.AW(AW), .SW(SW), .PW(PW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_req   (push_req),
    .pop_req    (pop_req),
    .fast_irq   (fast_irq),
    .push_hi    (push_hi),
    .push_lo    (push_lo),
    .sp_wr      (sp_wr),
    .sp_wdata   (sp_wdata),
    .flag_wr    (flag_wr),
    .flag_wdata (flag_wdata),
    .sp         (sp),
    .top_hi     (top_hi),
    .top_lo     (top_lo),
    .ovf_flag   (ovf_flag),
    .unf_flag   (unf_flag),
    .stk_err    (stk_err)
);

// File: tb/test_retstack.sv
`timescale 1ns/100ps
module test_retstack;
    localparam int AW = 16;
    localparam int SW = 16;
    localparam int PW = 4;

    typedef struct packed {
        logic        push;
        logic        pop;
        logic        fast;
        logic        spw;
        logic [3:0]  spd;
        logic        fw;
        logic [1:0]  fd;
        logic [15:0] hi;
        logic [15:0] lo;
        logic [3:0]  esp;
        logic [15:0] ehi;
        logic [15:0] elo;
        logic        eovf;
        logic        eunf;
        logic        eerr;
    } vec_t;

    localparam int NV = 17;
    // push pop fast spw spd fw fd hi lo | esp ehi elo eovf eunf eerr
    localparam vec_t VECS [NV] = '{
        '{1'b1,1'b0,1'b0,1'b0,4'd0, 1'b0,2'b00,16'hA001,16'hB001, 4'd1, 16'hA001,16'hB001,1'b0,1'b0,1'b0}, // R2
        '{1'b1,1'b0,1'b0,1'b0,4'd0, 1'b0,2'b00,16'hA002,16'hB002, 4'd2, 16'hA002,16'hB002,1'b0,1'b0,1'b0}, // R2
        '{1'b1,1'b0,1'b1,1'b0,4'd0, 1'b0,2'b00,16'hA003,16'hB003, 4'd2, 16'hA002,16'hB002,1'b0,1'b0,1'b0}, // R5
        '{1'b1,1'b1,1'b0,1'b0,4'd0, 1'b0,2'b00,16'hA004,16'hB004, 4'd2, 16'hA004,16'hB004,1'b0,1'b0,1'b0}, // R4
        '{1'b0,1'b1,1'b0,1'b0,4'd0, 1'b0,2'b00,16'h0,   16'h0,    4'd1, 16'hA001,16'hB001,1'b0,1'b0,1'b0}, // R3
        '{1'b0,1'b1,1'b0,1'b0,4'd0, 1'b0,2'b00,16'h0,   16'h0,    4'd0, 16'h0,   16'h0,   1'b0,1'b0,1'b0}, // R3
        '{1'b0,1'b1,1'b0,1'b0,4'd0, 1'b0,2'b00,16'h0,   16'h0,    4'd15,16'h0,   16'h0,   1'b0,1'b1,1'b1}, // R7
        '{1'b0,1'b0,1'b0,1'b0,4'd0, 1'b0,2'b00,16'h0,   16'h0,    4'd15,16'h0,   16'h0,   1'b0,1'b1,1'b0}, // R8 R10
        '{1'b0,1'b0,1'b0,1'b0,4'd0, 1'b1,2'b00,16'h0,   16'h0,    4'd15,16'h0,   16'h0,   1'b0,1'b0,1'b0}, // R8
        '{1'b1,1'b0,1'b0,1'b0,4'd0, 1'b0,2'b00,16'hA005,16'hB005, 4'd0, 16'hA005,16'hB005,1'b1,1'b0,1'b1}, // R6
        '{1'b1,1'b0,1'b0,1'b1,4'd14,1'b0,2'b00,16'hA0FF,16'hB0FF, 4'd14,16'h0,   16'h0,   1'b1,1'b0,1'b0}, // R9
        '{1'b1,1'b0,1'b0,1'b0,4'd0, 1'b0,2'b00,16'hA006,16'hB006, 4'd15,16'hA006,16'hB006,1'b1,1'b0,1'b0}, // R10
        '{1'b0,1'b1,1'b1,1'b0,4'd0, 1'b0,2'b00,16'h0,   16'h0,    4'd14,16'h0,   16'h0,   1'b1,1'b0,1'b0}, // R5
        '{1'b0,1'b0,1'b0,1'b0,4'd0, 1'b1,2'b10,16'h0,   16'h0,    4'd14,16'h0,   16'h0,   1'b0,1'b1,1'b0}, // R8
        '{1'b0,1'b1,1'b0,1'b1,4'd0, 1'b0,2'b00,16'h0,   16'h0,    4'd0, 16'hA005,16'hB005,1'b0,1'b1,1'b0}, // R9
        '{1'b0,1'b1,1'b0,1'b0,4'd0, 1'b1,2'b00,16'h0,   16'h0,    4'd15,16'hA006,16'hB006,1'b0,1'b1,1'b1}, // R8 R7
        '{1'b1,1'b0,1'b1,1'b0,4'd0, 1'b0,2'b00,16'hA007,16'hB007, 4'd15,16'hA006,16'hB006,1'b0,1'b1,1'b0}  // R5 R10
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          push_req = 1'b0, pop_req = 1'b0, fast_irq = 1'b0;
    logic [AW-1:0] push_hi = '0;
    logic [SW-1:0] push_lo = '0;
    logic          sp_wr = 1'b0;
    logic [PW-1:0] sp_wdata = '0;
    logic          flag_wr = 1'b0;
    logic [1:0]    flag_wdata = '0;
    logic [PW-1:0] sp;
    logic [AW-1:0] top_hi;
    logic [SW-1:0] top_lo;
    logic          ovf_flag, unf_flag, stk_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    retstack #(.AW(AW), .SW(SW), .PW(PW)) i_retstack (.*);

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        push_req = 1'b0; pop_req = 1'b0; fast_irq = 1'b0;
        sp_wr = 1'b0; flag_wr = 1'b0;
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk_reset_state();
        chk("R1", "sp", 32'(sp), 32'd0);
        chk("R1", "ovf", 32'(ovf_flag), 32'd0);
        chk("R1", "unf", 32'(unf_flag), 32'd0);
        chk("R1", "err", 32'(stk_err), 32'd0);
        chk("R1", "top_hi", 32'(top_hi), 32'd0);
        chk("R1", "top_lo", 32'(top_lo), 32'd0);
    endtask

    // Watchdog: counts a hang as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        rst_n = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
        @(negedge clk);
        chk_reset_state();

        // Vector table walk.
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            push_req = VECS[i].push; pop_req = VECS[i].pop; fast_irq = VECS[i].fast;
            sp_wr = VECS[i].spw; sp_wdata = VECS[i].spd;
            flag_wr = VECS[i].fw; flag_wdata = VECS[i].fd;
            push_hi = VECS[i].hi; push_lo = VECS[i].lo;
            step();
            idle_inputs();
            chk("vec", $sformatf("%0d sp", i), 32'(sp), 32'(VECS[i].esp));
            chk("vec", $sformatf("%0d top_hi", i), 32'(top_hi), 32'(VECS[i].ehi));
            chk("vec", $sformatf("%0d top_lo", i), 32'(top_lo), 32'(VECS[i].elo));
            chk("vec", $sformatf("%0d ovf", i), 32'(ovf_flag), 32'(VECS[i].eovf));
            chk("vec", $sformatf("%0d unf", i), 32'(unf_flag), 32'(VECS[i].eunf));
            chk("vec", $sformatf("%0d err", i), 32'(stk_err), 32'(VECS[i].eerr));
        end

        // R2 R3: fill fifteen levels and drain them in reverse order.
        @(negedge clk);
        sp_wr = 1'b1; sp_wdata = '0; flag_wr = 1'b1; flag_wdata = 2'b00;
        step();
        idle_inputs();
        for (int lv = 1; lv <= 15; lv++) begin
            @(negedge clk);
            push_req = 1'b1; push_hi = 16'h1000 + 16'(lv); push_lo = 16'h2000 + 16'(lv);
            step();
            idle_inputs();
            chk("R2", "fill sp", 32'(sp), 32'(lv));
        end
        chk("R10", "no err at level 15", 32'(stk_err), 32'd0);
        for (int lv = 15; lv >= 1; lv--) begin
            @(negedge clk);
            chk("R3", "drain hi", 32'(top_hi), 32'h1000 + 32'(lv));
            chk("R3", "drain lo", 32'(top_lo), 32'h2000 + 32'(lv));
            pop_req = 1'b1;
            step();
            idle_inputs();
            chk("R3", "drain sp", 32'(sp), 32'(lv - 1));
        end
        chk("R10", "ovf after drain", 32'(ovf_flag), 32'd0);
        chk("R10", "unf after drain", 32'(unf_flag), 32'd0);
        chk("R10", "err after drain", 32'(stk_err), 32'd0);

        // R1: reset in mid-run restores the empty state.
        @(negedge clk);
        pop_req = 1'b1;
        step();
        idle_inputs();
        @(negedge clk);
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
        @(negedge clk);
        chk_reset_state();

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule